// File: doc/BRIEF.md
# I2C Bus-State and Start-Request Controller

This block is the control core that sits beside the shift register of an I2C master/slave port. It watches the (asynchronous) SDA and SCL line levels, recognises START and STOP conditions, and keeps a flag telling software whether the bus is currently owned by anyone. It also produces the two open-drain pull-down enables that place a START or a STOP on the lines when software asks for one.

A start request is refused when the bus is busy and reservation is turned off: no line is touched and a sticky failure flag is raised, which software clears by writing one. With reservation on, the request is parked and launched as soon as the bus is released. Because the busy flag cannot be trusted right after the port is switched on, software can force the detector into the released state. An interrupt pulse is raised on the 8th or 9th SCL falling edge of each byte, and optionally on every STOP seen on the bus.

Top module: `i2c_bus_state_ctrl`

## Requirements
- R1: The busy flag goes to 1 after SDA falls while SCL is high (START) and returns to 0 after SDA rises while SCL is high (STOP); line levels pass through a two-stage synchroniser before detection.
- R2: A one-cycle pulse on `init_bus` forces the busy flag to 0 on the next cycle, regardless of the line levels, and it overrides a condition detected in the same cycle.
- R3: A start request from the idle state with the bus free asserts `sda_pull` from the next cycle while `scl_pull` stays 0 for exactly `hold_cycles` cycles; then both pulls are asserted and held.
- R4: With `rsv_off` = 1 and the bus busy, a start request leaves both pulls at 0 and sets `start_fail`; the flag stays 1 until a cycle with `clr_fail` = 1 and no new rejection (a new rejection wins).
- R5: With `rsv_off` = 0 and the bus busy, a start request drives no pull while the bus stays busy, and the START sequence of R3 begins once the bus is released.
- R6: A stop request while both pulls are held releases `scl_pull` on the next cycle, keeps `sda_pull` for `hold_cycles` cycles, then releases it; a stop request in any other state has no effect.
- R7: `irq` is a single-cycle pulse on the 8th SCL falling edge when `irq_on_9th` = 0, or on the 9th when it is 1; falling edges are counted 1 to 9 and wrap to 1, and the count restarts at every START or STOP.
- R8: A detected STOP produces an `irq` pulse when `stop_irq_en` = 1 and none when it is 0.
- R9: After reset both pulls, `bus_busy`, `start_fail` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_line | input | 1 | SDA level seen on the bus (asynchronous) |
| scl_line | input | 1 | SCL level seen on the bus (asynchronous) |
| init_bus | input | 1 | Force the bus-state detector to released |
| rsv_off | input | 1 | 1 = refuse start requests on a busy bus |
| irq_on_9th | input | 1 | 0 = interrupt on 8th SCL fall, 1 = on 9th |
| stop_irq_en | input | 1 | Interrupt on STOP detection |
| req_start | input | 1 | One-cycle start request |
| req_stop | input | 1 | One-cycle stop request |
| clr_fail | input | 1 | Write-one-to-clear for `start_fail` |
| hold_cycles | input | 8 | System clocks between the two line transitions |
| sda_pull | output | 1 | Pull SDA low (open-drain enable) |
| scl_pull | output | 1 | Pull SCL low (open-drain enable) |
| bus_busy | output | 1 | Bus currently owned |
| start_fail | output | 1 | Sticky start-refused flag |
| irq | output | 1 | Interrupt request pulse |

## Verification
The assertions guard the cycle-level invariants: the initialisation pulse always yields a released bus, a START always sets busy, SCL is never pulled before SDA and SDA is never freed while SCL is held, the failure flag never drops without a clear, the interrupt is never wider than one cycle and never follows a STOP while that interrupt is disabled, and the edge count never exceeds nine. Only the bench scenarios can show the exact hold-cycle timing of the generated conditions, the parking and later launch of a reserved request, and the right number of interrupts across bytes of random length with either edge selection.

// File: rtl/i2c_bsc_pkg.sv
package i2c_bsc_pkg;

    typedef enum logic [2:0] {
        GS_IDLE,
        GS_PEND,
        GS_SDA,
        GS_OWN,
        GS_SCL
    } gen_state_e;

    localparam int unsigned EDGES_PER_BYTE = 9;
    localparam int unsigned EDGE_CNT_W     = $clog2(EDGES_PER_BYTE + 1);

endpackage

// File: rtl/i2c_bsc_detect.sv
module i2c_bsc_detect #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_i,
    input  logic scl_i,
    input  logic init_i,
    output logic start_det_o,
    output logic stop_det_o,
    output logic scl_fall_o,
    output logic busy_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sda_sh;
        logic [SYNC_STAGES-1:0] scl_sh;
        logic                   sda_prev;
        logic                   scl_prev;
        logic                   busy;
    } det_t;

    det_t q, d;
    logic sda_s, scl_s;

    assign sda_s = q.sda_sh[SYNC_STAGES-1];
    assign scl_s = q.scl_sh[SYNC_STAGES-1];

    always_comb begin
        d          = q;
        d.sda_sh   = {q.sda_sh[SYNC_STAGES-2:0], sda_i};
        d.scl_sh   = {q.scl_sh[SYNC_STAGES-2:0], scl_i};
        d.sda_prev = sda_s;
        d.scl_prev = scl_s;
        if (init_i)
            d.busy = 1'b0;
        else if (start_det_o)
            d.busy = 1'b1;
        else if (stop_det_o)
            d.busy = 1'b0;
    end

    assign start_det_o = scl_s && q.scl_prev && q.sda_prev && !sda_s;
    assign stop_det_o  = scl_s && q.scl_prev && !q.sda_prev && sda_s;
    assign scl_fall_o  = q.scl_prev && !scl_s;
    assign busy_o      = q.busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sda_sh   <= '1;
            q.scl_sh   <= '1;
            q.sda_prev <= 1'b1;
            q.scl_prev <= 1'b1;
            q.busy     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    p_init_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> !busy_o);

    p_busy_on_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det_o && !init_i) |=> busy_o);

endmodule

// File: rtl/i2c_bsc_gen.sv
module i2c_bsc_gen
    import i2c_bsc_pkg::*;
#(
    parameter int unsigned HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start_i,
    input  logic              req_stop_i,
    input  logic              clr_fail_i,
    input  logic              rsv_off_i,
    input  logic              busy_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              sda_pull_o,
    output logic              scl_pull_o,
    output logic              fail_o
);

    typedef struct packed {
        gen_state_e        st;
        logic [HOLD_W-1:0] cnt;
        logic              fail;
    } gen_t;

    gen_t q, d;
    logic hold_done;
    logic reject;

    assign hold_done = ({1'b0, q.cnt} + (HOLD_W+1)'(1)) >= {1'b0, hold_i};
    assign reject    = (q.st == GS_IDLE) && req_start_i && busy_i && rsv_off_i;

    always_comb begin
        d = q;
        unique case (q.st)
            GS_IDLE: begin
                d.cnt = '0;
                if (req_start_i) begin
                    if (!busy_i)        d.st = GS_SDA;
                    else if (!rsv_off_i) d.st = GS_PEND;
                end
            end
            GS_PEND: begin
                d.cnt = '0;
                if (!busy_i) d.st = GS_SDA;
            end
            GS_SDA: begin
                if (hold_done) begin
                    d.st  = GS_OWN;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            GS_OWN: begin
                d.cnt = '0;
                if (req_stop_i) d.st = GS_SCL;
            end
            GS_SCL: begin
                if (hold_done) begin
                    d.st  = GS_IDLE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = GS_IDLE;
        endcase

        if (reject)
            d.fail = 1'b1;
        else if (clr_fail_i)
            d.fail = 1'b0;
    end

    assign sda_pull_o = (q.st == GS_SDA) || (q.st == GS_OWN) || (q.st == GS_SCL);
    assign scl_pull_o = (q.st == GS_OWN);
    assign fail_o     = q.fail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= GS_IDLE;
            q.cnt  <= '0;
            q.fail <= 1'b0;
        end else begin
            q <= d;
        end
    end

    p_scl_after_sda_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_o) |-> sda_pull_o);

    p_sda_freed_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_o) |-> !scl_pull_o);

    p_fail_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !clr_fail_i) |=> fail_o);

    p_reject_no_pull_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> (!sda_pull_o && fail_o));

endmodule

// File: rtl/i2c_bsc_irq.sv
module i2c_bsc_irq
    import i2c_bsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_det_i,
    input  logic stop_det_i,
    input  logic scl_fall_i,
    input  logic on_9th_i,
    input  logic stop_irq_en_i,
    output logic irq_o
);

    typedef struct packed {
        logic [EDGE_CNT_W-1:0] cnt;
        logic                  irq;
    } irq_t;

    irq_t q, d;
    logic [EDGE_CNT_W-1:0] sel;
    logic [EDGE_CNT_W-1:0] cnt_next;

    assign sel = on_9th_i ? EDGE_CNT_W'(EDGES_PER_BYTE) : EDGE_CNT_W'(EDGES_PER_BYTE - 1);
    assign cnt_next = (q.cnt >= EDGE_CNT_W'(EDGES_PER_BYTE)) ? EDGE_CNT_W'(1)
                                                            : q.cnt + 1'b1;

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        if (start_det_i || stop_det_i) begin
            d.cnt = '0;
            d.irq = stop_det_i && stop_irq_en_i;
        end else if (scl_fall_i) begin
            d.cnt = cnt_next;
            d.irq = (cnt_next == sel);
        end
    end

    assign irq_o = q.irq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= '0;
            q.irq <= 1'b0;
        end else begin
            q <= d;
        end
    end

    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= EDGE_CNT_W'(EDGES_PER_BYTE));

    p_stop_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det_i && !stop_irq_en_i) |=> !irq_o);

endmodule

// File: rtl/i2c_bus_state_ctrl.sv
module i2c_bus_state_ctrl #(
    parameter int unsigned HOLD_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_line,
    input  logic              scl_line,
    input  logic              init_bus,
    input  logic              rsv_off,
    input  logic              irq_on_9th,
    input  logic              stop_irq_en,
    input  logic              req_start,
    input  logic              req_stop,
    input  logic              clr_fail,
    input  logic [HOLD_W-1:0] hold_cycles,
    output logic              sda_pull,
    output logic              scl_pull,
    output logic              bus_busy,
    output logic              start_fail,
    output logic              irq
);

    logic start_det, stop_det, scl_fall;

    i2c_bsc_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_i       (sda_line),
        .scl_i       (scl_line),
        .init_i      (init_bus),
        .start_det_o (start_det),
        .stop_det_o  (stop_det),
        .scl_fall_o  (scl_fall),
        .busy_o      (bus_busy)
    );

    i2c_bsc_gen #(.HOLD_W(HOLD_W)) u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_start_i (req_start),
        .req_stop_i  (req_stop),
        .clr_fail_i  (clr_fail),
        .rsv_off_i   (rsv_off),
        .busy_i      (bus_busy),
        .hold_i      (hold_cycles),
        .sda_pull_o  (sda_pull),
        .scl_pull_o  (scl_pull),
        .fail_o      (start_fail)
    );

    i2c_bsc_irq u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_det_i   (start_det),
        .stop_det_i    (stop_det),
        .scl_fall_i    (scl_fall),
        .on_9th_i      (irq_on_9th),
        .stop_irq_en_i (stop_irq_en),
        .irq_o         (irq)
    );

endmodule

// File: tb/test_i2c_bus_state_ctrl.sv
`timescale 1ns/1ps
module test_i2c_bus_state_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_sda = 1'b1, ext_scl = 1'b1;
    logic       init_bus = 1'b0, rsv_off = 1'b0, irq_on_9th = 1'b0, stop_irq_en = 1'b0;
    logic       req_start = 1'b0, req_stop = 1'b0, clr_fail = 1'b0;
    logic [7:0] hold_cycles = 8'd4;
    logic       sda_pull, scl_pull, bus_busy, start_fail, irq;
    logic       sda_line, scl_line;

    int total = 0;
    int bad   = 0;
    int irq_seen = 0;

    always #2.5 clk = ~clk;

    assign sda_line = ext_sda & ~sda_pull;
    assign scl_line = ext_scl & ~scl_pull;

    i2c_bus_state_ctrl i_i2c_bus_state_ctrl (
        .clk, .rst_n, .sda_line, .scl_line, .init_bus, .rsv_off, .irq_on_9th,
        .stop_irq_en, .req_start, .req_stop, .clr_fail, .hold_cycles,
        .sda_pull, .scl_pull, .bus_busy, .start_fail, .irq
    );

    always @(negedge clk) if (irq) irq_seen++;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_irqs(input int n, input bit on9, input bit sen);
        int c = 0;
        for (int k = 1; k <= n; k++)
            if (((k - 1) % 9) + 1 == (on9 ? 9 : 8)) c++;
        return c + (sen ? 1 : 0);
    endfunction

    task automatic pulse_start();
        req_start = 1'b1; wait_n(1); req_start = 1'b0;
    endtask

    task automatic pulse_stop();
        req_stop = 1'b1; wait_n(1); req_stop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        wait_n(3);
        // R9 reset state
        check("R9 sda_pull", sda_pull, 0);
        check("R9 scl_pull", scl_pull, 0);
        check("R9 busy", bus_busy, 0);
        check("R9 fail", start_fail, 0);
        check("R9 irq", irq, 0);
        rst_n = 1'b1;
        wait_n(4);

        // R6 stop request while idle is ignored
        pulse_stop();
        wait_n(3);
        check("R6 idle stop sda", sda_pull, 0);
        check("R6 idle stop scl", scl_pull, 0);

        // R1 external START / STOP
        ext_sda = 1'b0; wait_n(8);
        check("R1 busy after START", bus_busy, 1);
        // R4 refused start on busy bus with reservation off
        rsv_off = 1'b1;
        pulse_start();
        check("R4 no sda pull", sda_pull, 0);
        wait_n(3);
        check("R4 no pull later", sda_pull, 0);
        check("R4 fail set", start_fail, 1);
        wait_n(5);
        check("R4 fail sticky", start_fail, 1);
        clr_fail = 1'b1; wait_n(1); clr_fail = 1'b0;
        check("R4 fail cleared", start_fail, 0);
        // R4 rejection wins over clear
        clr_fail = 1'b1; req_start = 1'b1; wait_n(1); clr_fail = 1'b0; req_start = 1'b0;
        check("R4 set beats clear", start_fail, 1);
        clr_fail = 1'b1; wait_n(1); clr_fail = 1'b0;
        rsv_off = 1'b0;

        // R2 init forces released while line still shows busy
        init_bus = 1'b1; wait_n(1); init_bus = 1'b0;
        check("R2 init clears busy", bus_busy, 0);
        wait_n(5);
        check("R2 stays released", bus_busy, 0);
        ext_sda = 1'b1; wait_n(8);
        check("R1 busy after STOP", bus_busy, 0);

        // R3 start sequence timing with hold 4
        hold_cycles = 8'd4;
        pulse_start();
        check("R3 sda pulled", sda_pull, 1);
        check("R3 scl free", scl_pull, 0);
        wait_n(3);
        check("R3 scl free at end of hold", scl_pull, 0);
        wait_n(1);
        check("R3 scl pulled", scl_pull, 1);
        check("R3 sda still pulled", sda_pull, 1);
        wait_n(6);
        check("R1 own START seen busy", bus_busy, 1);
        check("R3 lines held", sda_pull & scl_pull, 1);

        // R6 stop sequence
        pulse_stop();
        check("R6 scl released", scl_pull, 0);
        check("R6 sda kept", sda_pull, 1);
        wait_n(3);
        check("R6 sda kept at end of hold", sda_pull, 1);
        wait_n(1);
        check("R6 sda released", sda_pull, 0);
        wait_n(6);
        check("R1 own STOP seen free", bus_busy, 0);

        // R5 reservation: parked until released
        ext_sda = 1'b0; wait_n(8);
        pulse_start();
        wait_n(5);
        check("R5 parked no pull", sda_pull, 0);
        check("R5 no fail", start_fail, 0);
        ext_sda = 1'b1; wait_n(8);
        check("R5 start launched", sda_pull, 1);
        wait_n(8);
        check("R5 start completed", scl_pull, 1);
        pulse_stop();
        wait_n(12);
        check("R5 lines back free", sda_pull | scl_pull, 0);

        // R7 / R8 random bytes on the bus
        for (int it = 0; it < 12; it++) begin
            int n;
            bit on9, sen;
            n   = $urandom_range(25, 1);
            on9 = $urandom_range(1, 0);
            sen = $urandom_range(1, 0);
            if (it == 0) begin n = 8; on9 = 1'b0; sen = 1'b0; end
            if (it == 1) begin n = 8; on9 = 1'b1; sen = 1'b0; end
            if (it == 2) begin n = 18; on9 = 1'b1; sen = 1'b1; end
            irq_on_9th = on9; stop_irq_en = sen;
            wait_n(2);
            irq_seen = 0;
            ext_sda = 1'b0; wait_n(8);
            for (int k = 0; k < n; k++) begin
                ext_scl = 1'b0; wait_n(4);
                ext_scl = 1'b1; wait_n(4);
            end
            ext_sda = 1'b1; wait_n(8);
            check($sformatf("R7 R8 irq count n=%0d sel9=%0d stop_en=%0d", n, on9, sen),
                  irq_seen, exp_irqs(n, on9, sen));
            check("R1 busy released after byte", bus_busy, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule